// File: doc/BRIEF.md
# Operand-Snooping Reservation Station Bank

This block holds a small pool of waiting operations in front of a single non-pipelined arithmetic unit. An upstream issue stage hands it one operation per cycle. The operation carries an opcode and two sources. Each source is either an immediate value or the nonzero tag of the station whose result it still needs. The bank places the operation in its lowest free station. The issue port reports not-ready while every station is occupied.

Every cycle, the bank compares each pending source tag against the result broadcast bus. On a match it copies the broadcast data into that source. No register file read is needed again. Once a station holds both values and the unit is free, the bank dispatches it. The unit counts down a fixed latency and computes a sum or a difference. It then presents the result with the station's own tag, so that outside logic can put it on the broadcast bus. The station is released in the same cycle the result appears.

Top module: `rs_bank`

## Requirements
- R1: After reset all stations are free, `iss_ready` is 1 and `res_valid` is 0.
- R2: An issue (`iss_valid` high while `iss_ready` is high) fills the lowest-index free station. `iss_ready` is 0 exactly while every station is busy, and an issue offered then is dropped.
- R3: A source whose tag is 0 takes its value from the issue port and is ready at once.
- R4: While `bc_valid` is high, every busy station whose pending source tag equals `bc_tag` stores `bc_data` into that source and marks it ready. Several stations and both sources of one station may capture the same broadcast.
- R5: If a broadcast matches a source tag in the same cycle that source is issued, the broadcast data is captured.
- R6: A station is dispatched only when both sources are ready. Among ready stations, the lowest index goes first.
- R7: A dispatched operation produces a one-cycle `res_valid` pulse `EXEC_LAT` cycles later. `res_data` is the first source plus the second when op is 0, and the first minus the second when op is 1, modulo 2^DATA_W. `res_tag` is `BASE_TAG` plus the station index (1, 2, 3 by default).
- R8: The unit holds at most one operation at a time, so successive result pulses are at least `EXEC_LAT` cycles apart.
- R9: A station is released in the cycle its result is presented, so `iss_ready` is 1 whenever `res_valid` is 1.
- R10: A broadcast whose tag matches no pending source, or that occurs while `bc_valid` is 0, changes no station.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 1 | 0 add, 1 subtract |
| iss_src1_tag | input | TAG_W | Producer tag of first source, 0 if value given |
| iss_src1_val | input | DATA_W | First source value |
| iss_src2_tag | input | TAG_W | Producer tag of second source, 0 if value given |
| iss_src2_val | input | DATA_W | Second source value |
| iss_ready | output | 1 | A station is free |
| bc_valid | input | 1 | Broadcast bus carries a result |
| bc_tag | input | TAG_W | Tag of broadcasting station |
| bc_data | input | DATA_W | Broadcast result value |
| res_valid | output | 1 | Result pulse from the unit |
| res_tag | output | TAG_W | Tag of the finishing station |
| res_data | output | DATA_W | Computed result |

## Verification
The bench goes after a broadcast that arrives in the same cycle as the issue of its consumer. A design that looks only at stored tags would miss this wakeup, and the operation would never finish. It has two stations wake on one broadcast and checks the result order: picking the wrong priority swaps the tags of the results. A station with only one ready source must stay put, or a result appears early with a wrong value. Two further cases cover foreign broadcast tags and issues offered while the bank is full; a leak in either shows up as an unexpected result. Subtraction that wraps and the reuse of a freed low station are also exercised.

// File: rtl/rs_pkg.sv
package rs_pkg;
   typedef enum logic {
      OP_ADD = 1'b0,
      OP_SUB = 1'b1
   } rs_op_e;
endpackage

// File: rtl/rs_entry.sv
module rs_entry #(
   parameter int TAG_W  = 4,
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                alloc_i,
   input  rs_pkg::rs_op_e      op_i,
   input  logic [TAG_W-1:0]    qa_i,
   input  logic [DATA_W-1:0]   va_i,
   input  logic [TAG_W-1:0]    qb_i,
   input  logic [DATA_W-1:0]   vb_i,
   input  logic                bc_valid_i,
   input  logic [TAG_W-1:0]    bc_tag_i,
   input  logic [DATA_W-1:0]   bc_data_i,
   input  logic                start_i,
   input  logic                release_i,
   output logic                busy_o,
   output logic                ready_o,
   output rs_pkg::rs_op_e      op_o,
   output logic [DATA_W-1:0]   va_o,
   output logic [DATA_W-1:0]   vb_o
);
   localparam int NSRC = 2;

   logic                busy_q, exec_q;
   rs_pkg::rs_op_e      op_q;
   logic [TAG_W-1:0]    q_in  [NSRC];
   logic [DATA_W-1:0]   v_in  [NSRC];
   logic [TAG_W-1:0]    q_q   [NSRC];
   logic [DATA_W-1:0]   v_q   [NSRC];
   logic [NSRC-1:0]     src_rdy;

   assign q_in[0] = qa_i;
   assign q_in[1] = qb_i;
   assign v_in[0] = va_i;
   assign v_in[1] = vb_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         exec_q <= 1'b0;
         op_q   <= rs_pkg::OP_ADD;
      end else if (alloc_i) begin
         busy_q <= 1'b1;
         exec_q <= 1'b0;
         op_q   <= op_i;
      end else begin
         if (start_i)   exec_q <= 1'b1;
         if (release_i) begin
            busy_q <= 1'b0;
            exec_q <= 1'b0;
         end
      end
   end

   for (genvar k = 0; k < NSRC; k++) begin : g_src
      logic hit_new, hit_old;
      assign hit_new = bc_valid_i && (q_in[k] != '0) && (bc_tag_i == q_in[k]);
      assign hit_old = bc_valid_i && (q_q[k]  != '0) && (bc_tag_i == q_q[k]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q_q[k] <= '0;
            v_q[k] <= '0;
         end else if (alloc_i) begin
            if (hit_new) begin
               q_q[k] <= '0;
               v_q[k] <= bc_data_i;
            end else begin
               q_q[k] <= q_in[k];
               v_q[k] <= v_in[k];
            end
         end else if (busy_q && hit_old) begin
            q_q[k] <= '0;
            v_q[k] <= bc_data_i;
         end
      end

      assign src_rdy[k] = (q_q[k] == '0);
   end

   assign busy_o  = busy_q;
   assign ready_o = busy_q && !exec_q && (&src_rdy);
   assign op_o    = op_q;
   assign va_o    = v_q[0];
   assign vb_o    = v_q[1];
endmodule

// File: rtl/rs_pick.sv
module rs_pick #(
   parameter int N         = 3,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] gnt_o,
   output logic         any_o
);
   if (LOW_FIRST) begin : g_low
      always_comb begin
         logic found;
         found = 1'b0;
         gnt_o = '0;
         for (int i = 0; i < N; i++) begin
            if (req_i[i] && !found) begin
               gnt_o[i] = 1'b1;
               found    = 1'b1;
            end
         end
      end
   end else begin : g_high
      always_comb begin
         logic found;
         found = 1'b0;
         gnt_o = '0;
         for (int i = N-1; i >= 0; i--) begin
            if (req_i[i] && !found) begin
               gnt_o[i] = 1'b1;
               found    = 1'b1;
            end
         end
      end
   end

   assign any_o = |req_i;
endmodule

// File: rtl/rs_exec_unit.sv
module rs_exec_unit #(
   parameter int TAG_W  = 4,
   parameter int DATA_W = 32,
   parameter int LAT    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  rs_pkg::rs_op_e    op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [TAG_W-1:0]  tag_i,
   output logic              free_o,
   output logic              finish_o,
   output logic              res_valid_o,
   output logic [TAG_W-1:0]  res_tag_o,
   output logic [DATA_W-1:0] res_data_o
);
   localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;
   localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(LAT - 1);

   logic              busy_q;
   logic [CNT_W-1:0]  cnt_q;
   rs_pkg::rs_op_e    op_q;
   logic [DATA_W-1:0] a_q, b_q;
   logic [TAG_W-1:0]  tag_q;

   assign finish_o = busy_q && (cnt_q == '0);
   assign free_o   = !busy_q || finish_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         cnt_q       <= '0;
         op_q        <= rs_pkg::OP_ADD;
         a_q         <= '0;
         b_q         <= '0;
         tag_q       <= '0;
         res_valid_o <= 1'b0;
         res_tag_o   <= '0;
         res_data_o  <= '0;
      end else begin
         res_valid_o <= 1'b0;
         if (finish_o) begin
            busy_q      <= 1'b0;
            res_valid_o <= 1'b1;
            res_tag_o   <= tag_q;
            res_data_o  <= (op_q == rs_pkg::OP_SUB) ? (a_q - b_q) : (a_q + b_q);
         end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
         end
         if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_INIT;
            op_q   <= op_i;
            a_q    <= a_i;
            b_q    <= b_i;
            tag_q  <= tag_i;
         end
      end
   end
endmodule

// File: rtl/rs_bank.sv
module rs_bank #(
   parameter int NUM_ENT   = 3,
   parameter int TAG_W     = 4,
   parameter int DATA_W    = 32,
   parameter int EXEC_LAT  = 2,
   parameter int BASE_TAG  = 1,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic              iss_op,
   input  logic [TAG_W-1:0]  iss_src1_tag,
   input  logic [DATA_W-1:0] iss_src1_val,
   input  logic [TAG_W-1:0]  iss_src2_tag,
   input  logic [DATA_W-1:0] iss_src2_val,
   output logic              iss_ready,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   output logic              res_valid,
   output logic [TAG_W-1:0]  res_tag,
   output logic [DATA_W-1:0] res_data
);
   localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

   if (NUM_ENT < 1)                           begin : g_bad_ent  $error("NUM_ENT must be at least 1"); end
   if (EXEC_LAT < 1)                          begin : g_bad_lat  $error("EXEC_LAT must be at least 1"); end
   if (BASE_TAG < 1)                          begin : g_bad_base $error("BASE_TAG 0 is reserved"); end
   if (BASE_TAG + NUM_ENT > (1 << TAG_W))     begin : g_bad_tagw $error("TAG_W too narrow for stations"); end

   logic [NUM_ENT-1:0] busy, ready, disp, alloc, alloc_gnt, disp_gnt, rel;
   logic               any_free, any_ready;
   rs_pkg::rs_op_e     ent_op [NUM_ENT];
   logic [DATA_W-1:0]  ent_va [NUM_ENT];
   logic [DATA_W-1:0]  ent_vb [NUM_ENT];

   logic               fu_free, fu_finish, fu_start;
   rs_pkg::rs_op_e     sel_op;
   logic [DATA_W-1:0]  sel_a, sel_b;
   logic [TAG_W-1:0]   sel_tag;
   logic [IDX_W-1:0]   sel_idx, exec_idx_q;
   rs_pkg::rs_op_e     iss_op_e;

   assign iss_op_e = rs_pkg::rs_op_e'(iss_op);

   rs_pick #(.N(NUM_ENT), .LOW_FIRST(1'b1)) u_alloc_pick (
      .req_i (~busy),
      .gnt_o (alloc_gnt),
      .any_o (any_free)
   );

   assign iss_ready = any_free;
   assign alloc     = alloc_gnt & {NUM_ENT{iss_valid}};

   rs_pick #(.N(NUM_ENT), .LOW_FIRST(LOW_FIRST)) u_disp_pick (
      .req_i (ready),
      .gnt_o (disp_gnt),
      .any_o (any_ready)
   );

   assign fu_start = any_ready && fu_free;
   assign disp     = disp_gnt & {NUM_ENT{fu_free}};

   for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
      assign rel[i] = fu_finish && (exec_idx_q == IDX_W'(i));

      rs_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_ent (
         .clk        (clk),
         .rst_n      (rst_n),
         .alloc_i    (alloc[i]),
         .op_i       (iss_op_e),
         .qa_i       (iss_src1_tag),
         .va_i       (iss_src1_val),
         .qb_i       (iss_src2_tag),
         .vb_i       (iss_src2_val),
         .bc_valid_i (bc_valid),
         .bc_tag_i   (bc_tag),
         .bc_data_i  (bc_data),
         .start_i    (disp[i]),
         .release_i  (rel[i]),
         .busy_o     (busy[i]),
         .ready_o    (ready[i]),
         .op_o       (ent_op[i]),
         .va_o       (ent_va[i]),
         .vb_o       (ent_vb[i])
      );
   end

   always_comb begin
      sel_op  = rs_pkg::OP_ADD;
      sel_a   = '0;
      sel_b   = '0;
      sel_idx = '0;
      for (int i = 0; i < NUM_ENT; i++) begin
         if (disp_gnt[i]) begin
            sel_op  = ent_op[i];
            sel_a   = ent_va[i];
            sel_b   = ent_vb[i];
            sel_idx = IDX_W'(i);
         end
      end
      sel_tag = TAG_W'(BASE_TAG) + TAG_W'(sel_idx);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        exec_idx_q <= '0;
      else if (fu_start) exec_idx_q <= sel_idx;
   end

   rs_exec_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W), .LAT(EXEC_LAT)) u_fu (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (fu_start),
      .op_i        (sel_op),
      .a_i         (sel_a),
      .b_i         (sel_b),
      .tag_i       (sel_tag),
      .free_o      (fu_free),
      .finish_o    (fu_finish),
      .res_valid_o (res_valid),
      .res_tag_o   (res_tag),
      .res_data_o  (res_data)
   );
endmodule

// File: rtl/rs_bank_chk.sv
module rs_bank_chk #(
   parameter int NUM_ENT  = 3,
   parameter int TAG_W    = 4,
   parameter int EXEC_LAT = 2,
   parameter int BASE_TAG = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               iss_valid,
   input logic               iss_ready,
   input logic               res_valid,
   input logic [TAG_W-1:0]   res_tag,
   input logic [NUM_ENT-1:0] busy,
   input logic [NUM_ENT-1:0] ready,
   input logic [NUM_ENT-1:0] disp
);
   logic [TAG_W-1:0]   rel_idx;
   logic [NUM_ENT-1:0] res_bit;
   assign rel_idx = res_tag - TAG_W'(BASE_TAG);
   assign res_bit = NUM_ENT'(1) << rel_idx;

   // R2: at most one station is filled per cycle
   assert_one_alloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(busy) <= $countones($past(busy)) + 1));

   // R2: an issue offered while full adds no station
   assert_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_ready) |=> ($countones(busy) <= $countones($past(busy))));

   // R6: one dispatch at a time, only from a ready station
   assert_single_disp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(disp));
   assert_disp_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (disp & ~ready) == '0);

   // R9: finishing station is already free when its result shows
   assert_free_on_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ((busy & res_bit) == '0 && iss_ready));

   // R8: result is a single-cycle pulse when latency exceeds one
   if (EXEC_LAT > 1) begin : g_pulse
      assert_res_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
         res_valid |=> !res_valid);
   end
endmodule

bind rs_bank rs_bank_chk #(
   .NUM_ENT (NUM_ENT),
   .TAG_W   (TAG_W),
   .EXEC_LAT(EXEC_LAT),
   .BASE_TAG(BASE_TAG)
) u_chk (.*);

// File: tb/tb_rs_bank.sv
module tb_rs_bank;
   localparam int NUM_ENT  = 3;
   localparam int TAG_W    = 4;
   localparam int DATA_W   = 32;
   localparam int EXEC_LAT = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              iss_valid = 1'b0;
   logic              iss_op = 1'b0;
   logic [TAG_W-1:0]  iss_src1_tag = '0;
   logic [DATA_W-1:0] iss_src1_val = '0;
   logic [TAG_W-1:0]  iss_src2_tag = '0;
   logic [DATA_W-1:0] iss_src2_val = '0;
   logic              iss_ready;
   logic              bc_valid = 1'b0;
   logic [TAG_W-1:0]  bc_tag = '0;
   logic [DATA_W-1:0] bc_data = '0;
   logic              res_valid;
   logic [TAG_W-1:0]  res_tag;
   logic [DATA_W-1:0] res_data;

   always #10 clk = ~clk;

   rs_bank #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W), .DATA_W(DATA_W), .EXEC_LAT(EXEC_LAT)) dut (.*);

   typedef struct packed {
      logic [TAG_W-1:0]  tag;
      logic [DATA_W-1:0] data;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_fail   = 0;
   int   cyc      = 0;
   int   last_res = -1000;
   bit   done     = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   function automatic logic [DATA_W-1:0] model(input bit op, input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
      return op ? a - b : a + b;
   endfunction

   function automatic void expect_res(input int tag, input logic [DATA_W-1:0] d);
      exp_t e;
      e.tag  = TAG_W'(tag);
      e.data = d;
      exp_q.push_back(e);
   endfunction

   // monitor: compare each result pulse against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R10", "unexpected result tag", res_tag, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(res_tag == e.tag, "R7", "result tag", res_tag, e.tag);
            check(res_data == e.data, "R7", "result data", res_data, e.data);
         end
         check(cyc - last_res >= EXEC_LAT, "R8", "result spacing", cyc - last_res, EXEC_LAT);
         check(iss_ready == 1'b1, "R9", "iss_ready with result", iss_ready, 1);
         last_res = cyc;
      end
   end

   task automatic issue(input bit op, input int q1, input int v1, input int q2, input int v2);
      iss_valid    = 1'b1;
      iss_op       = op;
      iss_src1_tag = TAG_W'(q1);
      iss_src1_val = DATA_W'(v1);
      iss_src2_tag = TAG_W'(q2);
      iss_src2_val = DATA_W'(v2);
      @(negedge clk);
      iss_valid    = 1'b0;
   endtask

   task automatic bcast(input int tag, input int data);
      bc_valid = 1'b1;
      bc_tag   = TAG_W'(tag);
      bc_data  = DATA_W'(data);
      @(negedge clk);
      bc_valid = 1'b0;
   endtask

   task automatic drain(input string req);
      int n = 0;
      while (exp_q.size() != 0 && n < 60) begin
         @(negedge clk);
         n++;
      end
      check(exp_q.size() == 0, req, "pending results", exp_q.size(), 0);
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "R1", "watchdog expired", cyc, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(iss_ready == 1'b1, "R1", "iss_ready after reset", iss_ready, 1);
      check(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);

      // R3 / R7: both values present, add
      expect_res(1, model(0, 5, 7));
      issue(0, 0, 5, 0, 7);
      drain("R3");

      // R7: subtraction wraps modulo 2^DATA_W
      expect_res(1, model(1, 3, 5));
      issue(1, 0, 3, 0, 5);
      drain("R7");

      // R5: broadcast in the same cycle as the consumer's issue
      bc_valid = 1'b1; bc_tag = 4'd12; bc_data = 32'd40;
      expect_res(1, model(0, 40, 2));
      issue(0, 12, 0, 0, 2);
      bc_valid = 1'b0;
      drain("R5");

      // R2 / R4 / R6 / R10: fill the bank with waiting stations
      issue(0, 9, 0, 0, 10);     // station 0
      issue(1, 9, 0, 0, 1);      // station 1
      issue(0, 11, 0, 9, 0);     // station 2
      check(iss_ready == 1'b0, "R2", "iss_ready when full", iss_ready, 0);
      issue(0, 0, 1, 0, 1);      // dropped: bank full
      issue(0, 0, 2, 0, 2);      // dropped: bank full
      bcast(10, 777);            // R10: foreign tag
      bc_tag = 4'd9; bc_data = 32'd555;
      repeat (2) @(negedge clk); // R10: bc_valid low with a matching tag
      repeat (4) @(negedge clk);
      check(iss_ready == 1'b0, "R10", "bank still full", iss_ready, 0);
      check(exp_q.size() == 0, "R10", "no results emitted", exp_q.size(), 0);
      // R4 / R6: one broadcast wakes stations 0 and 1, lowest goes first
      expect_res(1, model(0, 100, 10));
      expect_res(2, model(1, 100, 1));
      bcast(9, 100);
      drain("R6");
      // R6: station 2 has only one source ready and must wait
      repeat (4) @(negedge clk);
      check(iss_ready == 1'b1, "R6", "bank has free stations", iss_ready, 1);
      expect_res(3, model(0, 5, 100));
      bcast(11, 5);
      drain("R4");

      // R2: freed lowest station is reused
      issue(0, 13, 0, 0, 1);     // station 0 waits
      expect_res(2, model(0, 2, 3));
      issue(0, 0, 2, 0, 3);      // station 1
      drain("R2");
      expect_res(2, model(1, 4, 1));
      issue(1, 0, 4, 0, 1);      // station 1 again, lowest free
      drain("R2");
      expect_res(1, model(0, 6, 1));
      bcast(13, 6);
      drain("R4");

      // R4: both sources of one station on the same tag
      expect_res(1, model(1, 9, 9));
      issue(1, 14, 0, 14, 0);
      bcast(14, 9);
      drain("R4");

      finish_run();
   end
endmodule